// File: doc/BRIEF.md
# Sign-Magnitude Shift-Add Multiplier

This block multiplies two unsigned magnitudes of `W` bits, each with its own sign bit, and returns a `2W`-bit magnitude and a sign. It works one multiplier bit at a time. For each bit it may add the multiplicand into an accumulator, and then it shifts a carry flag, the accumulator and the multiplier register right by one place. When the last bit has been used, the high half of the product is in the accumulator and the low half is in the multiplier register.

A caller puts the operands on the inputs and raises `start` for one cycle while the block is idle. The block captures the operands and works out the product sign at once, as the exclusive-OR of the two input signs. It then runs `W` add/shift steps of two cycles each. After that it gives a single-cycle `done` strobe. The product outputs keep their value until the next accepted start.

Top module: `sm_seq_mult`

## Requirements
- R1: While reset is held and after reset is released, `done` and `busy` are 0, and `prod_mag` and `prod_sgn` are 0.
- R2: `prod_sgn` at `done` equals `mcand_sgn XOR mplier_sgn` as captured in the accepted start cycle.
- R3: `prod_mag` at `done` equals the unsigned product `mcand_mag * mplier_mag`. Bits `2W-1..W` are the upper half and bits `W-1..0` are the lower half.
- R4: `done` is high for exactly one cycle. It rises `2W+1` clock edges after the edge that accepts start, counting that edge as the first.
- R5: A `start` pulse while `busy` is high is ignored. The operation in progress completes with its original operands and its original result.
- R6: `busy` goes high on the edge that accepts start, stays high through the `done` cycle, and is low in the cycle that follows.
- R7: If either magnitude is zero, the product magnitude is zero and the sign is still the XOR of the input signs.
- R8: While the block is idle and `start` is low, `prod_mag` and `prod_sgn` do not change, even if the operand inputs change.
- R9: The all-ones operands give `(2^W-1)^2`. The carry out of every partial addition is kept, so none is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication; accepted only when idle |
| mcand_mag | input | W | Multiplicand magnitude |
| mcand_sgn | input | 1 | Multiplicand sign, 1 = negative |
| mplier_mag | input | W | Multiplier magnitude |
| mplier_sgn | input | 1 | Multiplier sign, 1 = negative |
| busy | output | 1 | High from acceptance through the done cycle |
| done | output | 1 | One-cycle completion strobe |
| prod_mag | output | 2W | Product magnitude |
| prod_sgn | output | 1 | Product sign |

## Verification
The bench runs every operand and sign combination at `W=4` and random operands at `W=8`. It also drives directed cases: zero operands, all-ones operands, and a second `start` pulse in the middle of a run. A design with an off-by-one step count would drop the top multiplier bit or shift once too often, so odd multipliers or the all-ones case would come out wrong and `done` would arrive early or late. A design without the carry flag would lose the top product bit on the all-ones case. A design that accepted a start while busy would reload mid-run and give a garbled product. A sign taken from live inputs rather than the captured ones would fail the intrusion case.

// File: rtl/sm_mult_pkg.sv
package sm_mult_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADD   = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } mult_state_e;

  // Sum of two W-bit magnitudes, W+1 bits wide (carry on top).
  function automatic logic [64:0] add_carry(input logic [63:0] a, input logic [63:0] b, input int w);
    logic [64:0] s;
    logic [64:0] mask;
    mask = (65'd1 << (w + 1)) - 65'd1;
    s = ({1'b0, a} + {1'b0, b}) & mask;
    return s;
  endfunction

endpackage

// File: rtl/sm_mult_ctrl.sv
module sm_mult_ctrl
  import sm_mult_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load_en,
  output logic add_en,
  output logic shift_en,
  output logic last_step,
  output logic busy,
  output logic done
);

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] SC_INIT = CW'(W - 1);

  mult_state_e state_q, state_d;
  logic [CW-1:0] sc_q;

  assign load_en   = (state_q == ST_IDLE) && start;
  assign add_en    = (state_q == ST_ADD);
  assign shift_en  = (state_q == ST_SHIFT);
  assign last_step = shift_en && (sc_q == '0);
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_ADD;
      ST_ADD:   state_d = ST_SHIFT;
      ST_SHIFT: state_d = last_step ? ST_DONE : ST_ADD;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sc_q    <= '0;
    end else begin
      state_q <= state_d;
      if (load_en)
        sc_q <= SC_INIT;
      else if (shift_en && !last_step)
        sc_q <= sc_q - 1'b1;
    end
  end

endmodule

// File: rtl/sm_mult_datapath.sv
module sm_mult_datapath
  import sm_mult_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_en,
  input  logic           add_en,
  input  logic           shift_en,
  input  logic [W-1:0]   mcand_mag,
  input  logic           mcand_sgn,
  input  logic [W-1:0]   mplier_mag,
  input  logic           mplier_sgn,
  output logic [2*W-1:0] prod_mag,
  output logic           prod_sgn
);

  logic [W-1:0] acc_q;
  logic [W-1:0] mq_q;
  logic [W-1:0] mb_q;
  logic         cy_q;
  logic         sgn_q;
  logic [64:0]  sum_wide;
  logic [W:0]   sum;

  assign sum_wide = add_carry(64'(acc_q), 64'(mb_q), W);
  assign sum      = sum_wide[W:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      mq_q  <= '0;
      mb_q  <= '0;
      cy_q  <= 1'b0;
      sgn_q <= 1'b0;
    end else if (load_en) begin
      acc_q <= '0;
      cy_q  <= 1'b0;
      mq_q  <= mplier_mag;
      mb_q  <= mcand_mag;
      sgn_q <= mcand_sgn ^ mplier_sgn;
    end else if (add_en) begin
      if (mq_q[0]) {cy_q, acc_q} <= sum;
    end else if (shift_en) begin
      {cy_q, acc_q, mq_q} <= {1'b0, cy_q, acc_q, mq_q[W-1:1]};
    end
  end

  assign prod_mag = {acc_q, mq_q};
  assign prod_sgn = sgn_q;

endmodule

// File: rtl/sm_seq_mult.sv
module sm_seq_mult #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   mcand_mag,
  input  logic           mcand_sgn,
  input  logic [W-1:0]   mplier_mag,
  input  logic           mplier_sgn,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] prod_mag,
  output logic           prod_sgn
);

  // Internal events, named for the bound checker.
  logic load_en;
  logic add_en;
  logic shift_en;
  logic last_step;

  sm_mult_ctrl #(.W(W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .load_en   (load_en),
    .add_en    (add_en),
    .shift_en  (shift_en),
    .last_step (last_step),
    .busy      (busy),
    .done      (done)
  );

  sm_mult_datapath #(.W(W)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .add_en     (add_en),
    .shift_en   (shift_en),
    .mcand_mag  (mcand_mag),
    .mcand_sgn  (mcand_sgn),
    .mplier_mag (mplier_mag),
    .mplier_sgn (mplier_sgn),
    .prod_mag   (prod_mag),
    .prod_sgn   (prod_sgn)
  );

endmodule

// File: rtl/sm_mult_chk.sv
module sm_mult_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           mcand_sgn,
  input logic           mplier_sgn,
  input logic [2*W-1:0] prod_mag,
  input logic           prod_sgn,
  input logic           add_en,
  input logic           shift_en,
  input logic           last_step
);

  logic [15:0] run_cnt;
  logic        exp_sgn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      exp_sgn <= 1'b0;
    end else if (start && !busy) begin
      run_cnt <= '0;
      exp_sgn <= mcand_sgn ^ mplier_sgn;
    end else if (busy) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_cnt == 16'(2 * W)));

  assert_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (prod_sgn == exp_sgn));

  assert_busy_on_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_idle_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(prod_mag) && $stable(prod_sgn)));

  assert_add_then_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    add_en |=> shift_en);

  assert_last_step_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> done);

endmodule

bind sm_seq_mult sm_mult_chk #(.W(W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .mcand_sgn  (mcand_sgn),
  .mplier_sgn (mplier_sgn),
  .prod_mag   (prod_mag),
  .prod_sgn   (prod_sgn),
  .add_en     (add_en),
  .shift_en   (shift_en),
  .last_step  (last_step)
);

// File: tb/sm_seq_mult_tb_top.sv
module sm_seq_mult_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  // W = 8 instance
  logic        start8 = 1'b0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic        as8 = 1'b0, bs8 = 1'b0;
  logic        busy8, done8, sgn8;
  logic [15:0] mag8;

  // W = 4 instance
  logic        start4 = 1'b0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic        as4 = 1'b0, bs4 = 1'b0;
  logic        busy4, done4, sgn4;
  logic [7:0]  mag4;

  sm_seq_mult #(.W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start8),
    .mcand_mag(a8), .mcand_sgn(as8), .mplier_mag(b8), .mplier_sgn(bs8),
    .busy(busy8), .done(done8), .prod_mag(mag8), .prod_sgn(sgn8));

  sm_seq_mult #(.W(4)) dut_n4_i (
    .clk(clk), .rst_n(rst_n), .start(start4),
    .mcand_mag(a4), .mcand_sgn(as4), .mplier_mag(b4), .mplier_sgn(bs4),
    .busy(busy4), .done(done4), .prod_mag(mag4), .prod_sgn(sgn4));

  function automatic longint exp_mag(input longint x, input longint y);
    longint acc = 0;
    for (int i = 0; i < 16; i++) if (y[i]) acc += (x << i);
    return acc;
  endfunction

  function automatic bit exp_sgn(input bit x, input bit y);
    return (x != y);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
      $finish;
    end
  end

  task automatic op8(input logic [7:0] a, input logic as, input logic [7:0] b, input logic bs,
                     input bit intrude, input string mtag);
    int k;
    longint em;
    bit es;
    em = exp_mag(longint'(a), longint'(b));
    es = exp_sgn(as, bs);
    @(negedge clk);
    a8 = a; as8 = as; b8 = b; bs8 = bs; start8 = 1'b1;
    @(negedge clk);
    start8 = 1'b0;
    k = 1;
    chk(busy8 == 1'b1, "R6 busy after accept", longint'(busy8), 1);
    while (!done8 && k < 100) begin
      if (intrude && k == 3) begin
        start8 = 1'b1; a8 = ~a; b8 = ~b; as8 = ~as;
      end else begin
        start8 = 1'b0;
      end
      @(negedge clk);
      k++;
    end
    start8 = 1'b0;
    chk(done8 && k == 17, "R4 done latency", k, 17);
    chk(mag8 == 16'(em), mtag, longint'(mag8), em);
    chk(sgn8 == es, "R2 sign", longint'(sgn8), longint'(es));
    @(negedge clk);
    chk(!done8 && !busy8, "R6/R4 idle after done", longint'({busy8, done8}), 0);
  endtask

  task automatic op4(input logic [3:0] a, input logic as, input logic [3:0] b, input logic bs);
    int k;
    longint em;
    bit es;
    em = exp_mag(longint'(a), longint'(b));
    es = exp_sgn(as, bs);
    @(negedge clk);
    a4 = a; as4 = as; b4 = b; bs4 = bs; start4 = 1'b1;
    @(negedge clk);
    start4 = 1'b0;
    k = 1;
    while (!done4 && k < 100) begin
      @(negedge clk);
      k++;
    end
    chk(done4 && k == 9, "R4 done latency W4", k, 9);
    chk(mag4 == 8'(em), "R3 magnitude W4", longint'(mag4), em);
    chk(sgn4 == es, "R2 sign W4", longint'(sgn4), longint'(es));
  endtask

  initial begin
    logic [15:0] held_mag;
    logic        held_sgn;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1: reset state, during reset and just after release
    chk(!busy8 && !done8 && mag8 == 0 && !sgn8, "R1 reset W8", longint'(mag8), 0);
    chk(!busy4 && !done4 && mag4 == 0 && !sgn4, "R1 reset W4", longint'(mag4), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy8 && !done8 && mag8 == 0, "R1 after release", longint'({busy8, done8}), 0);

    // Directed corner cases
    op8(8'd0,   1'b1, 8'd200, 1'b0, 1'b0, "R7 zero multiplicand");
    op8(8'd77,  1'b1, 8'd0,   1'b1, 1'b0, "R7 zero multiplier");
    op8(8'hFF,  1'b0, 8'hFF,  1'b1, 1'b0, "R9 all ones");
    op8(8'd1,   1'b0, 8'h80,  1'b0, 1'b0, "R3 top multiplier bit");
    op8(8'd3,   1'b1, 8'd5,   1'b0, 1'b1, "R5 start ignored while busy");

    // R8: hold while idle with inputs moving
    held_mag = mag8;
    held_sgn = sgn8;
    for (int i = 0; i < 4; i++) begin
      a8 = 8'(i * 37); b8 = 8'(i * 91); as8 = i[0]; bs8 = ~i[0];
      @(negedge clk);
    end
    chk(mag8 == held_mag && sgn8 == held_sgn, "R8 hold while idle", longint'(mag8), longint'(held_mag));

    // Random W = 8
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom();
      op8(r[7:0], r[16], r[15:8], r[17], 1'b0, "R3 magnitude W8");
    end

    // Exhaustive W = 4
    for (int i = 0; i < 1024; i++) begin
      op4(i[3:0], i[8], i[7:4], i[9]);
    end

    summary();
    $finish;
  end

endmodule